// File: doc/BRIEF.md
# Posted Write Redelivery Controller

This block sits beside a bridge's posted-write buffer and decides how each new try at delivering buffered write data to a target is made. A transaction is accepted with its starting byte address and bus command. The first attempt is launched on the next cycle. After that, the block waits for the target's termination code for the attempt.

The next step depends on that code. A retry relaunches the attempt unchanged. A disconnect relaunches it from the first DWORD not yet accepted. If a Memory-Write-and-Invalidate was partly accepted before a disconnect, the rest goes out as an ordinary memory write. A target abort, or running out of attempts, ends the transaction and can raise a system-error request, subject to the enable and disable controls.

The attempt budget is a parameter: 2^24 by default, and small in simulation.

Top module: `pwr_redeliver_ctl`

## Requirements
- R1: After reset, busy, att_start, nodeliv_evt, rx_tabort_set, sig_serr_set and serr_req are 0, and att_addr and att_cmd are 0.
- R2: When term_kind is retry (2'b01) and data_left is 1, the next attempt drives the same att_addr and att_cmd as the failed attempt.
- R3: When term_kind is disconnect (2'b10) and data_left is 1, the next attempt's att_addr is the previous att_addr plus 4 times term_words.
- R4: On a disconnect with term_words nonzero and att_cmd equal to Memory-Write-and-Invalidate (4'hF), the next attempt uses memory write (4'h7). With term_words zero, the command is kept.
- R5: att_start pulses for one cycle, one cycle after an accepted txn_valid (while not busy) or after a retry or disconnect with data_left set. txn_valid while busy and term_valid while idle have no effect.
- R6: When an attempt ends in retry or disconnect with data_left set and ATTEMPT_LIMIT attempts have already been made, no new attempt starts. Instead nodeliv_evt pulses and busy falls.
- R7: On that non-delivery, serr_req and sig_serr_set pulse only when serr_en is 1 and nodeliv_dis is 0.
- R8: A target abort (2'b11) pulses rx_tabort_set, ends the transaction, and pulses serr_req and sig_serr_set if serr_en is 1, whatever nodeliv_dis is.
- R9: A normal end (2'b00), or a retry or disconnect with data_left 0, ends the transaction without a new attempt. It clears att_addr, att_cmd and the attempt count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_valid | input | 1 | Offer a new posted transaction |
| txn_addr | input | ADDR_W | Starting byte address of the transaction |
| txn_cmd | input | 4 | Bus command of the transaction |
| term_valid | input | 1 | Termination of the current attempt is reported |
| term_kind | input | 2 | 00 normal, 01 retry, 10 disconnect, 11 target abort |
| term_words | input | WCNT_W | DWORDs accepted during the attempt |
| data_left | input | 1 | Buffered data of the transaction remains |
| serr_en | input | 1 | System-error reporting enable |
| nodeliv_dis | input | 1 | Suppresses error reporting for non-delivery |
| att_start | output | 1 | One-cycle strobe: launch an attempt |
| att_addr | output | ADDR_W | Address for the attempt |
| att_cmd | output | 4 | Command for the attempt |
| busy | output | 1 | A transaction is being delivered |
| nodeliv_evt | output | 1 | Pulse: attempt budget exhausted |
| rx_tabort_set | output | 1 | Pulse: set received-target-abort status |
| sig_serr_set | output | 1 | Pulse: set signaled-system-error status |
| serr_req | output | 1 | Pulse: system-error request |

## Verification
The assertions assume that a termination is reported only while an attempt is live. They also assume that term_words times four stays within the address range. The relaunch and limit properties further rely on serr_en and nodeliv_dis holding steady for the cycle in which an event is sampled.

The directed tasks keep to these conditions. Terminations are issued one at a time, only after att_start has been seen. Every control input is set a full cycle before the event that uses it, and word counts stay small.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
   typedef enum logic [1:0] {
      TK_NORMAL = 2'b00,
      TK_RETRY  = 2'b01,
      TK_DISC   = 2'b10,
      TK_ABORT  = 2'b11
   } term_e;

   localparam logic [3:0] CMD_MEMWR = 4'h7;
   localparam logic [3:0] CMD_MWI   = 4'hF;
endpackage

// File: rtl/pwr_addr_track.sv
module pwr_addr_track #(
   parameter int ADDR_W = 32,
   parameter int WCNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [3:0]        load_cmd,
   input  logic              advance,
   input  logic [WCNT_W-1:0] words,
   input  logic              clear,
   output logic [ADDR_W-1:0] addr_q,
   output logic [3:0]        cmd_q
);
   localparam int STEP_W = WCNT_W + 2;

   generate
      if (STEP_W >= ADDR_W) begin : g_bad_width
         $error("pwr_addr_track: ADDR_W must exceed WCNT_W+2");
      end
   endgenerate

   logic [ADDR_W-1:0] step;
   assign step = {{(ADDR_W-STEP_W){1'b0}}, words, 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cmd_q  <= '0;
      end else if (load) begin
         addr_q <= load_addr;
         cmd_q  <= load_cmd;
      end else if (clear) begin
         addr_q <= '0;
         cmd_q  <= '0;
      end else if (advance) begin
         addr_q <= addr_q + step;
         if (words != '0 && cmd_q == pwr_pkg::CMD_MWI)
            cmd_q <= pwr_pkg::CMD_MEMWR;
      end
   end

   AST_DISC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && !clear) |=> (addr_q == $past(addr_q) + {$past(words), 2'b00})); // R3
   AST_MWI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && !clear && words != '0) |=> (cmd_q != pwr_pkg::CMD_MWI)); // R4
endmodule

// File: rtl/pwr_attempt_ctr.sv
module pwr_attempt_ctr #(
   parameter int LIMIT = 1 << 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic first,
   input  logic again,
   input  logic clear,
   output logic at_limit
);
   localparam int CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("pwr_attempt_ctr: LIMIT must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (first)    cnt_q <= CNT_W'(1);
      else if (clear)    cnt_q <= '0;
      else if (again)    cnt_q <= cnt_q + 1'b1;
   end

   assign at_limit = (cnt_q == LIM_V);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM_V); // R6
   AST_NO_RELAUNCH_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (at_limit && !first) |-> !again); // R6
endmodule

// File: rtl/pwr_err_report.sv
module pwr_err_report (
   input  logic clk,
   input  logic rst_n,
   input  logic abort_ev,
   input  logic exhaust_ev,
   input  logic serr_en,
   input  logic nodeliv_dis,
   output logic nodeliv_q,
   output logic rx_tabort_q,
   output logic sig_serr_q,
   output logic serr_q
);
   logic raise;
   assign raise = serr_en & (abort_ev | (exhaust_ev & ~nodeliv_dis));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nodeliv_q   <= 1'b0;
         rx_tabort_q <= 1'b0;
         sig_serr_q  <= 1'b0;
         serr_q      <= 1'b0;
      end else begin
         nodeliv_q   <= exhaust_ev;
         rx_tabort_q <= abort_ev;
         sig_serr_q  <= raise;
         serr_q      <= raise;
      end
   end

   AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      serr_q |-> $past(serr_en)); // R7
   AST_SERR_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      serr_q |-> (rx_tabort_q || nodeliv_q)); // R8
endmodule

// File: rtl/pwr_redeliver_ctl.sv
module pwr_redeliver_ctl #(
   parameter int ADDR_W        = 32,
   parameter int WCNT_W        = 8,
   parameter int ATTEMPT_LIMIT = 1 << 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_valid,
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic [3:0]        txn_cmd,
   input  logic              term_valid,
   input  logic [1:0]        term_kind,
   input  logic [WCNT_W-1:0] term_words,
   input  logic              data_left,
   input  logic              serr_en,
   input  logic              nodeliv_dis,
   output logic              att_start,
   output logic [ADDR_W-1:0] att_addr,
   output logic [3:0]        att_cmd,
   output logic              busy,
   output logic              nodeliv_evt,
   output logic              rx_tabort_set,
   output logic              sig_serr_set,
   output logic              serr_req
);
   import pwr_pkg::*;

   term_e kind;
   logic  live_term, accept, fail_go, at_limit;
   logic  relaunch, exhaust, abort_ev, retire, finish;

   assign kind      = term_e'(term_kind);
   assign live_term = busy & term_valid;
   assign accept    = txn_valid & ~busy;
   assign fail_go   = live_term & data_left & (kind == TK_RETRY || kind == TK_DISC);
   assign relaunch  = fail_go & ~at_limit;
   assign exhaust   = fail_go & at_limit;
   assign abort_ev  = live_term & (kind == TK_ABORT);
   assign retire    = live_term & (kind == TK_NORMAL ||
                      ((kind == TK_RETRY || kind == TK_DISC) && !data_left));
   assign finish    = retire | exhaust | abort_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         att_start <= 1'b0;
      end else begin
         att_start <= accept | relaunch;
         if (accept)      busy <= 1'b1;
         else if (finish) busy <= 1'b0;
      end
   end

   pwr_addr_track #(.ADDR_W(ADDR_W), .WCNT_W(WCNT_W)) u_addr (
      .clk(clk), .rst_n(rst_n),
      .load(accept), .load_addr(txn_addr), .load_cmd(txn_cmd),
      .advance(relaunch & (kind == TK_DISC)), .words(term_words),
      .clear(finish),
      .addr_q(att_addr), .cmd_q(att_cmd)
   );

   pwr_attempt_ctr #(.LIMIT(ATTEMPT_LIMIT)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .first(accept), .again(relaunch), .clear(finish),
      .at_limit(at_limit)
   );

   pwr_err_report u_err (
      .clk(clk), .rst_n(rst_n),
      .abort_ev(abort_ev), .exhaust_ev(exhaust),
      .serr_en(serr_en), .nodeliv_dis(nodeliv_dis),
      .nodeliv_q(nodeliv_evt), .rx_tabort_q(rx_tabort_set),
      .sig_serr_q(sig_serr_set), .serr_q(serr_req)
   );

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      att_start |-> busy); // R5
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (att_start && !(busy && term_valid)) |=> !att_start); // R5
   AST_RETRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (relaunch && kind == TK_RETRY) |=> ($stable(att_addr) && $stable(att_cmd))); // R2
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && !txn_valid) |=> (att_addr == '0 && !busy)); // R9
endmodule

// File: tb/pwr_redeliver_ctl_test.sv
module pwr_redeliver_ctl_test;
   localparam int AW = 32;
   localparam int WW = 8;
   localparam int LIM = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txn_valid = 0, term_valid = 0, data_left = 0, serr_en = 0, nodeliv_dis = 0;
   logic [AW-1:0] txn_addr = '0;
   logic [3:0] txn_cmd = '0;
   logic [1:0] term_kind = '0;
   logic [WW-1:0] term_words = '0;
   logic att_start, busy, nodeliv_evt, rx_tabort_set, sig_serr_set, serr_req;
   logic [AW-1:0] att_addr;
   logic [3:0] att_cmd;

   int checks = 0, fails = 0;

   always #5 clk = ~clk;

   pwr_redeliver_ctl #(.ADDR_W(AW), .WCNT_W(WW), .ATTEMPT_LIMIT(LIM)) uut (
      .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_addr(txn_addr),
      .txn_cmd(txn_cmd), .term_valid(term_valid), .term_kind(term_kind),
      .term_words(term_words), .data_left(data_left), .serr_en(serr_en),
      .nodeliv_dis(nodeliv_dis), .att_start(att_start), .att_addr(att_addr),
      .att_cmd(att_cmd), .busy(busy), .nodeliv_evt(nodeliv_evt),
      .rx_tabort_set(rx_tabort_set), .sig_serr_set(sig_serr_set), .serr_req(serr_req)
   );

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic begin_txn(logic [AW-1:0] a, logic [3:0] c);
      @(negedge clk);
      txn_valid = 1; txn_addr = a; txn_cmd = c;
      @(negedge clk);
      txn_valid = 0;
   endtask

   task automatic end_attempt(logic [1:0] k, logic [WW-1:0] w, logic left);
      @(negedge clk);
      term_valid = 1; term_kind = k; term_words = w; data_left = left;
      @(negedge clk);
      term_valid = 0;
   endtask

   task automatic t_reset();
      chk("R1", "busy", busy, 0);
      chk("R1", "att_start", att_start, 0);
      chk("R1", "att_addr", att_addr, 0);
      chk("R1", "att_cmd", att_cmd, 0);
      chk("R1", "serr_req", serr_req, 0);
      chk("R1", "nodeliv_evt", nodeliv_evt, 0);
   endtask

   task automatic t_retry();
      begin_txn(32'h1000, 4'h7);
      chk("R5", "first start", att_start, 1);
      chk("R5", "first addr", att_addr, 32'h1000);
      end_attempt(2'b01, 3, 1);
      chk("R2", "retry start", att_start, 1);
      chk("R2", "retry addr", att_addr, 32'h1000);
      chk("R2", "retry cmd", att_cmd, 4'h7);
      @(negedge clk);
      chk("R5", "pulse width", att_start, 0);
      end_attempt(2'b00, 2, 1);
      chk("R9", "normal busy", busy, 0);
      chk("R9", "normal addr cleared", att_addr, 0);
      chk("R9", "normal no start", att_start, 0);
   endtask

   task automatic t_disc();
      begin_txn(32'h2000, 4'hF);
      end_attempt(2'b10, 3, 1);
      chk("R3", "disc start", att_start, 1);
      chk("R3", "disc addr", att_addr, 32'h200C);
      chk("R4", "mwi downgraded", att_cmd, 4'h7);
      end_attempt(2'b10, 0, 0);
      chk("R9", "no data left busy", busy, 0);
      chk("R9", "no data left start", att_start, 0);
      begin_txn(32'h3000, 4'hF);
      end_attempt(2'b10, 0, 1);
      chk("R3", "zero word addr", att_addr, 32'h3000);
      chk("R4", "zero word keeps mwi", att_cmd, 4'hF);
      end_attempt(2'b01, 0, 0);
      chk("R9", "retry empty cmd cleared", att_cmd, 0);
   endtask

   task automatic t_limit(logic en, logic dis, logic exp_serr);
      serr_en = en; nodeliv_dis = dis;
      begin_txn(32'h4000, 4'h7);
      for (int i = 1; i < LIM; i++) begin
         end_attempt(2'b01, 0, 1);
         chk("R6", "relaunch under limit", att_start, 1);
      end
      end_attempt(2'b01, 0, 1);
      chk("R6", "no start at limit", att_start, 0);
      chk("R6", "nodeliv pulse", nodeliv_evt, 1);
      chk("R6", "busy dropped", busy, 0);
      chk("R7", "serr gating", serr_req, exp_serr);
      chk("R7", "sig serr gating", sig_serr_set, exp_serr);
      @(negedge clk);
      chk("R6", "nodeliv one cycle", nodeliv_evt, 0);
   endtask

   task automatic t_abort(logic en);
      serr_en = en; nodeliv_dis = 1;
      begin_txn(32'h5000, 4'h7);
      end_attempt(2'b11, 1, 1);
      chk("R8", "rx tabort", rx_tabort_set, 1);
      chk("R8", "abort serr", serr_req, en);
      chk("R8", "abort sig serr", sig_serr_set, en);
      chk("R8", "abort busy", busy, 0);
      chk("R8", "abort no start", att_start, 0);
   endtask

   task automatic t_ignore();
      end_attempt(2'b11, 1, 1);
      chk("R5", "idle term no abort", rx_tabort_set, 0);
      chk("R5", "idle term no start", att_start, 0);
      begin_txn(32'h6000, 4'h7);
      begin_txn(32'h7000, 4'hF);
      chk("R5", "busy txn no start", att_start, 0);
      chk("R5", "busy txn addr kept", att_addr, 32'h6000);
      chk("R5", "busy txn cmd kept", att_cmd, 4'h7);
      end_attempt(2'b00, 1, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      t_retry();
      t_disc();
      t_limit(1, 0, 1);
      t_limit(1, 1, 0);
      t_limit(0, 0, 0);
      t_abort(1);
      t_abort(0);
      t_ignore();
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule